// File: doc/BRIEF.md
# Transmit Underflow Recovery Controller

This block decides how the transmit path reacts when its data FIFO runs dry in the middle of a frame. It owns the transmitter-on status and the pointer into the transmit descriptor ring. A single control bit selects the reaction. With recovery off, an underflow shuts the transmitter down. With recovery on, the transmitter stays up. The block then walks the ring past the rest of the broken frame and restarts at the first descriptor that begins a new frame.

The descriptor store is reached through a simple combinational read port. The ring pointer is the address. The store returns an ownership flag and a start-of-frame flag for that descriptor. While the transmitter runs normally, the data path advances the pointer each time it finishes a descriptor. When the scan reaches a descriptor that the block does not yet own, it holds its position until ownership is granted. A start command turns the transmitter on and a stop command turns it off. A software reset returns the control bit, the transmitter status and the pointer to their reset values.

Top module: `tx_underrun_recovery`

## Requirements
- R1: After hardware reset, tx_on, recov_en, scanning, scan_wait and restart are 0, and ring_ptr is 0.
- R2: A cycle with cfg_we high loads cfg_wdata into recov_en, which is visible on its output port from the next cycle.
- R3: sw_reset clears recov_en, tx_on and scanning, and sets ring_ptr to 0, taking priority over every other input in that cycle.
- R4: stop_cmd clears tx_on and aborts any scan, and it leaves recov_en unchanged.
- R5: With recov_en at 0, an underflow while tx_on is 1 and no scan is active clears tx_on on the next cycle. ring_ptr does not change and no restart is issued.
- R6: With recov_en at 1, an underflow while tx_on is 1 and no scan is active keeps tx_on at 1, raises scanning, and moves ring_ptr one step past the descriptor that underflowed.
- R7: During a scan, each cycle in which the descriptor at ring_ptr is owned (rd_own=1) and is not a frame start (rd_sof=0) advances ring_ptr by one.
- R8: During a scan, a descriptor with rd_own=0 holds ring_ptr and raises scan_wait. The scan resumes in the first cycle after ownership appears.
- R9: When the scan meets an owned descriptor with rd_sof=1, restart is high for exactly one cycle on the next cycle. restart_idx then equals that descriptor's index, scanning drops, and ring_ptr stays on that descriptor.
- R10: ring_ptr wraps from RING_DEPTH-1 to 0, both during a scan and during normal advance.
- R11: With tx_on at 1 and no scan active, a desc_adv pulse advances ring_ptr by one. With tx_on at 0, desc_adv has no effect.
- R12: An underflow is ignored while tx_on is 0 or while a scan is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| sw_reset | input | 1 | Software reset pulse |
| cfg_we | input | 1 | Write strobe for the recovery-enable bit |
| cfg_wdata | input | 1 | Value written to the recovery-enable bit |
| start_cmd | input | 1 | Turn the transmitter on |
| stop_cmd | input | 1 | Turn the transmitter off |
| underflow | input | 1 | FIFO underflow pulse from the data path |
| desc_adv | input | 1 | Data path finished the current descriptor |
| rd_own | input | 1 | Descriptor at ring_ptr is owned by the block |
| rd_sof | input | 1 | Descriptor at ring_ptr starts a frame |
| recov_en | output | 1 | Recovery-enable bit read value |
| tx_on | output | 1 | Transmitter-on status |
| scanning | output | 1 | Recovery scan in progress |
| scan_wait | output | 1 | Scan held on a descriptor that is not owned |
| ring_ptr | output | $clog2(RING_DEPTH) | Current descriptor index, also the read address |
| restart | output | 1 | One-cycle pulse at the start of a new transmission |
| restart_idx | output | $clog2(RING_DEPTH) | Descriptor index where the new frame starts |

## Verification
The hardest cases to reach are a scan that has to wrap through the end of the ring, and a scan that finds the next frame start in the very slot that underflowed. Reaching them needs a chosen underflow position and a chosen distance to the next frame start. The bench places the pointer at every ring position by issuing advance pulses. For each position, it puts the only frame-start flag at every possible distance, from one step up to a full turn of the ring. It then checks both the restart index and the number of cycles the scan took. A separate run withholds ownership of one descriptor in the middle of a scan to hold it in the pending state.

// File: rtl/tx_underrun_recovery.sv
module tx_underrun_recovery #(
  parameter int RING_DEPTH = 16,
  localparam int IW = $clog2(RING_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_reset,
  input  logic          cfg_we,
  input  logic          cfg_wdata,
  input  logic          start_cmd,
  input  logic          stop_cmd,
  input  logic          underflow,
  input  logic          desc_adv,
  input  logic          rd_own,
  input  logic          rd_sof,
  output logic          recov_en,
  output logic          tx_on,
  output logic          scanning,
  output logic          scan_wait,
  output logic [IW-1:0] ring_ptr,
  output logic          restart,
  output logic [IW-1:0] restart_idx
);

  logic uf_hit, scan_step, scan_found;

  assign uf_hit     = underflow && tx_on && !scanning;
  assign scan_found = scanning && rd_own && rd_sof;
  assign scan_step  = scanning && rd_own && !rd_sof;
  assign scan_wait  = scanning && !rd_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recov_en <= 1'b0;
    end else if (sw_reset) begin
      recov_en <= 1'b0;
    end else if (cfg_we) begin
      recov_en <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_on       <= 1'b0;
      scanning    <= 1'b0;
      ring_ptr    <= '0;
      restart     <= 1'b0;
      restart_idx <= '0;
    end else if (sw_reset) begin
      tx_on       <= 1'b0;
      scanning    <= 1'b0;
      ring_ptr    <= '0;
      restart     <= 1'b0;
    end else if (stop_cmd) begin
      tx_on    <= 1'b0;
      scanning <= 1'b0;
      restart  <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (uf_hit) begin
        if (recov_en) begin
          scanning <= 1'b1;
          ring_ptr <= ring_ptr + 1'b1;
        end else begin
          tx_on <= 1'b0;
        end
      end else if (scan_found) begin
        scanning    <= 1'b0;
        restart     <= 1'b1;
        restart_idx <= ring_ptr;
      end else if (scan_step) begin
        ring_ptr <= ring_ptr + 1'b1;
      end else if (!scanning && tx_on && desc_adv) begin
        ring_ptr <= ring_ptr + 1'b1;
      end
      if (start_cmd && !tx_on) tx_on <= 1'b1;
    end
  end

  // R9
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart);

  // R5
  halt_on_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && tx_on && !scanning && !recov_en && !sw_reset && !stop_cmd)
      |=> (!tx_on && !restart));

  // R6
  keep_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && tx_on && !scanning && recov_en && !sw_reset && !stop_cmd)
      |=> (tx_on && scanning));

  // R8
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_wait && !sw_reset && !stop_cmd) |=> $stable(ring_ptr));

  // R3
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!recov_en && !tx_on && ring_ptr == '0));

  // R4
  stop_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !sw_reset && !cfg_we) |=> ($stable(recov_en) && !tx_on));

endmodule

// File: tb/tx_underrun_recovery_bench.sv
module tx_underrun_recovery_bench;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic sw_reset = 0, cfg_we = 0, cfg_wdata = 0, start_cmd = 0, stop_cmd = 0;
  logic underflow = 0, desc_adv = 0;
  logic rd_own, rd_sof;
  logic recov_en, tx_on, scanning, scan_wait, restart;
  logic [IW-1:0] ring_ptr, restart_idx;
  logic [N-1:0] own_m, sof_m;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  assign rd_own = own_m[ring_ptr];
  assign rd_sof = sof_m[ring_ptr];

  tx_underrun_recovery #(.RING_DEPTH(N)) u_tx_underrun_recovery (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .underflow(underflow), .desc_adv(desc_adv), .rd_own(rd_own), .rd_sof(rd_sof),
    .recov_en(recov_en), .tx_on(tx_on), .scanning(scanning), .scan_wait(scan_wait),
    .ring_ptr(ring_ptr), .restart(restart), .restart_idx(restart_idx));

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sw();
    sw_reset = 1; step(); sw_reset = 0;
  endtask

  task automatic set_en(logic v);
    cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0;
  endtask

  task automatic go_to(int s);
    pulse_sw(); start_cmd = 1; step(); start_cmd = 0;
    for (int i = 0; i < s; i++) begin desc_adv = 1; step(); end
    desc_adv = 0;
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    own_m = '1; sof_m = '0;
    @(negedge clk); step();
    // R1
    chk("R1 tx_on", tx_on, 0); chk("R1 en", recov_en, 0);
    chk("R1 ptr", ring_ptr, 0); chk("R1 restart", restart, 0);
    chk("R1 scanning", scanning, 0); chk("R1 scan_wait", scan_wait, 0);
    rst_n = 1; step();

    // R2
    set_en(1); chk("R2 write 1", recov_en, 1);
    set_en(0); chk("R2 write 0", recov_en, 0);
    set_en(1);
    // R4 stop leaves enable alone
    start_cmd = 1; step(); start_cmd = 0;
    stop_cmd = 1; step(); stop_cmd = 0;
    chk("R4 en kept", recov_en, 1); chk("R4 tx off", tx_on, 0);
    // R3
    pulse_sw(); chk("R3 en cleared", recov_en, 0);

    // R11 desc_adv ignored while off, R10 wrap on normal advance
    desc_adv = 1; step(); desc_adv = 0;
    chk("R11 off no adv", ring_ptr, 0);
    go_to(N - 1); chk("R11 adv", ring_ptr, N - 1);
    desc_adv = 1; step(); desc_adv = 0;
    chk("R10 wrap adv", ring_ptr, 0);

    // R5 halt without recovery
    go_to(3); set_en(0);
    underflow = 1; step(); underflow = 0;
    chk("R5 tx off", tx_on, 0); chk("R5 ptr", ring_ptr, 3); chk("R5 no restart", restart, 0);
    // R12 underflow while off ignored
    underflow = 1; step(); underflow = 0;
    chk("R12 off scanning", scanning, 0); chk("R12 off ptr", ring_ptr, 3);

    // R6 R7 R9 R10 sweep: every start, every distance to next frame start
    for (int s = 0; s < N; s++) begin
      for (int d = 1; d <= N; d++) begin
        int cyc, exp_idx;
        go_to(s); set_en(1);
        exp_idx = (s + d) % N;
        sof_m = '0; sof_m[exp_idx] = 1'b1;
        underflow = 1; step(); underflow = 0;
        chk("R6 tx stays on", tx_on, 1); chk("R6 scanning", scanning, 1);
        chk("R6 ptr skip", ring_ptr, (s + 1) % N);
        cyc = 0;
        while (!restart && cyc < 2 * N) begin
          if (cyc == 0 && d > 1) begin
            underflow = 1; step(); underflow = 0; cyc++;
            chk("R12 uf during scan", ring_ptr, (s + 2) % N);
          end else begin
            step(); cyc++;
          end
        end
        chk("R7 scan cycles", cyc, d);
        chk("R9 restart idx", restart_idx, exp_idx);
        chk("R10 ptr at sof", ring_ptr, exp_idx);
        chk("R9 scan done", scanning, 0);
        step(); chk("R9 one cycle", restart, 0);
      end
    end

    // R8 pending on unowned descriptor
    go_to(1); set_en(1);
    sof_m = '0; sof_m[6] = 1'b1; own_m = '1; own_m[4] = 1'b0;
    underflow = 1; step(); underflow = 0;
    step(); step();
    chk("R8 reached", ring_ptr, 4);
    for (int i = 0; i < 5; i++) begin
      step(); chk("R8 hold ptr", ring_ptr, 4); chk("R8 wait", scan_wait, 1);
    end
    own_m[4] = 1'b1; step();
    chk("R8 resumed", ring_ptr, 5); chk("R8 wait low", scan_wait, 0);
    step(); step();
    chk("R9 after wait", restart, 1); chk("R9 idx after wait", restart_idx, 6);

    // R4 stop aborts scan
    go_to(0); set_en(1); sof_m = '0;
    underflow = 1; step(); underflow = 0;
    stop_cmd = 1; step(); stop_cmd = 0;
    chk("R4 scan aborted", scanning, 0); chk("R4 en kept scan", recov_en, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule